// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block receives the serial stream that a PS/2 keyboard sends over its two open-collector lines, a slow clock and a data line. Both lines idle high and are pulled low by the keyboard. Each line passes through a synchroniser and a glitch filter running on the fast system clock. On each filtered falling edge of the keyboard clock, the data level is shifted into an eleven-bit frame.

A finished frame is checked for a low start bit, a high stop bit and odd parity across the data byte and the parity bit. A bad frame is dropped and reported with a one-cycle error pulse. Good bytes go to a sequence tracker. The tracker absorbs the extended prefix (E0) and the release prefix (F0), and then delivers the final code byte as one event record. The record holds the code, a release flag and an extended flag, and it stays in a register a processor can poll. A one-cycle strobe marks each new event. If the keyboard stops clocking in the middle of a frame, a timeout clears the bit counter so that later frames stay aligned.

Top module: `ps2_scan_receiver`

## Requirements
- R1: After reset, code_o is 0x00, release_o, extended_o, valid_o and frame_err_o are 0.
- R2: A frame is bit 0 start (0), bits 1..8 the data byte least-significant bit first, bit 9 parity, bit 10 stop (1), each taken from the data line at a falling edge of the keyboard clock. A valid frame carrying a byte other than E0 or F0 gives a one-cycle valid_o pulse with code_o equal to that byte.
- R3: A frame whose start bit is 1, whose stop bit is 0, or whose data plus parity bits hold an even number of ones gives a one-cycle frame_err_o pulse, no valid_o, and leaves code_o, release_o and extended_o unchanged.
- R4: A valid F0 byte produces no event; the next code byte is delivered with release_o = 1.
- R5: A valid E0 byte produces no event; the next code byte is delivered with extended_o = 1, and E0 F0 followed by a code gives both flags set.
- R6: Both flags clear after an event is delivered, so a following plain code byte reports release_o = 0 and extended_o = 0.
- R7: A frame error discards any pending E0 or F0 prefix.
- R8: If no falling keyboard-clock edge arrives for TIMEOUT_CYC system cycles while a frame is partly received, the bit count returns to zero, and the next complete frame decodes correctly.
- R9: A low pulse on the keyboard clock line that is shorter than FILT_LEN system cycles is not taken as an edge.
- R10: code_o, release_o and extended_o change only in the cycle in which valid_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk_i | input | 1 | Keyboard clock line, idles high |
| ps2_dat_i | input | 1 | Keyboard data line, idles high |
| code_o | output | 8 | Code byte of the latest event |
| release_o | output | 1 | Latest event was a key release |
| extended_o | output | 1 | Latest event carried the E0 prefix |
| valid_o | output | 1 | One-cycle pulse when a new event is stored |
| frame_err_o | output | 1 | One-cycle pulse when a frame is discarded |

## Verification
Every byte value except the two prefixes is sent as a plain frame. This separates bit-order, parity and latching faults, since each value has its own parity and bit pattern. Prefixed sequences (F0 x, E0 x, E0 F0 x) are mixed with plain codes, which shows that the flags are set and then cleared. Frames that break the start, stop or parity rule show that corrupt data is dropped and that pending prefixes are discarded with it. A truncated frame followed by a stall, and a short glitch on the clock line, each precede a good frame, so a missing timeout or a missing filter shows up as a misaligned or wrong byte.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;
  localparam int FRAME_BITS = 11;
  localparam logic [7:0] PFX_EXT = 8'hE0;
  localparam logic [7:0] PFX_REL = 8'hF0;

  // Odd parity holds when data plus parity carry an odd count of ones.
  function automatic logic parity_odd(input logic [8:0] dat_par);
    return ^dat_par;
  endfunction

  function automatic logic frame_ok(input logic [FRAME_BITS-1:0] f);
    return (f[0] == 1'b0) && (f[FRAME_BITS-1] == 1'b1) && parity_odd(f[9:1]);
  endfunction

  function automatic logic [7:0] frame_byte(input logic [FRAME_BITS-1:0] f);
    return f[8:1];
  endfunction
endpackage

// File: rtl/ps2_line_cond.sv
module ps2_line_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '1;
      cnt_q   <= '0;
      level_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (synced == level_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_LEN - 1)) begin
        level_o <= synced;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ps2_frame_shifter.sv
module ps2_frame_shifter
  import ps2rx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kclk_lvl_i,
  input  logic       kdat_lvl_i,
  output logic       byte_stb_o,
  output logic [7:0] byte_o,
  output logic       err_stb_o,
  output logic [3:0] bit_idx_o,
  output logic       timeout_o
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic                  kclk_prev_q;
  logic                  fall;
  logic [FRAME_BITS-1:0] shift_q;
  logic [FRAME_BITS-1:0] frame_w;
  logic [TW-1:0]         idle_q;
  logic                  last_bit;

  assign fall      = kclk_prev_q & ~kclk_lvl_i;
  assign frame_w   = {kdat_lvl_i, shift_q[FRAME_BITS-1:1]};
  assign last_bit  = (bit_idx_o == 4'(FRAME_BITS - 1));
  assign timeout_o = (bit_idx_o != 4'd0) && !fall && (idle_q == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kclk_prev_q <= 1'b1;
      shift_q     <= '1;
      bit_idx_o   <= '0;
      idle_q      <= '0;
      byte_stb_o  <= 1'b0;
      err_stb_o   <= 1'b0;
      byte_o      <= '0;
    end else begin
      kclk_prev_q <= kclk_lvl_i;
      byte_stb_o  <= 1'b0;
      err_stb_o   <= 1'b0;
      if (fall) begin
        shift_q <= frame_w;
        idle_q  <= '0;
        if (last_bit) begin
          bit_idx_o <= '0;
          if (frame_ok(frame_w)) begin
            byte_stb_o <= 1'b1;
            byte_o     <= frame_byte(frame_w);
          end else begin
            err_stb_o <= 1'b1;
          end
        end else begin
          bit_idx_o <= bit_idx_o + 4'd1;
        end
      end else if (timeout_o) begin
        bit_idx_o <= '0;
        idle_q    <= '0;
      end else if (bit_idx_o != 4'd0) begin
        idle_q <= idle_q + 1'b1;
      end else begin
        idle_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ps2_seq_tracker.sv
module ps2_seq_tracker
  import ps2rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_stb_i,
  input  logic [7:0] byte_i,
  input  logic       err_stb_i,
  output logic [7:0] code_o,
  output logic       rel_o,
  output logic       ext_o,
  output logic       valid_o
);
  logic rel_pend_q;
  logic ext_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_pend_q <= 1'b0;
      ext_pend_q <= 1'b0;
      code_o     <= '0;
      rel_o      <= 1'b0;
      ext_o      <= 1'b0;
      valid_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (err_stb_i) begin
        rel_pend_q <= 1'b0;
        ext_pend_q <= 1'b0;
      end else if (byte_stb_i) begin
        if (byte_i == PFX_EXT) begin
          ext_pend_q <= 1'b1;
        end else if (byte_i == PFX_REL) begin
          rel_pend_q <= 1'b1;
        end else begin
          code_o     <= byte_i;
          rel_o      <= rel_pend_q;
          ext_o      <= ext_pend_q;
          valid_o    <= 1'b1;
          rel_pend_q <= 1'b0;
          ext_pend_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ps2_scan_receiver.sv
module ps2_scan_receiver #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 8,
  parameter int TIMEOUT_CYC = 200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_i,
  input  logic       ps2_dat_i,
  output logic [7:0] code_o,
  output logic       release_o,
  output logic       extended_o,
  output logic       valid_o,
  output logic       frame_err_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_lvl;
  logic              byte_stb_w;
  logic [7:0]        byte_w;
  logic [3:0]        bit_idx_w;
  logic              timeout_w;

  assign line_raw = {ps2_dat_i, ps2_clk_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    ps2_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (line_raw[g]),
      .level_o (line_lvl[g])
    );
  end

  ps2_frame_shifter #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .kclk_lvl_i (line_lvl[0]),
    .kdat_lvl_i (line_lvl[1]),
    .byte_stb_o (byte_stb_w),
    .byte_o     (byte_w),
    .err_stb_o  (frame_err_o),
    .bit_idx_o  (bit_idx_w),
    .timeout_o  (timeout_w)
  );

  ps2_seq_tracker u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_stb_i (byte_stb_w),
    .byte_i     (byte_w),
    .err_stb_i  (frame_err_o),
    .code_o     (code_o),
    .rel_o      (release_o),
    .ext_o      (extended_o),
    .valid_o    (valid_o)
  );
endmodule

// File: rtl/ps2_scan_receiver_chk.sv
module ps2_scan_receiver_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_o,
  input logic       frame_err_o,
  input logic [7:0] code_o,
  input logic       release_o,
  input logic       extended_o,
  input logic       byte_stb_w,
  input logic [3:0] bit_idx_w,
  input logic       timeout_w
);
  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_valid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(byte_stb_w));

  assert_bit_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx_w <= 4'd10);

  assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);

  assert_err_no_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> !valid_o);

  assert_timeout_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_w |=> (bit_idx_w == 4'd0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(code_o) && $stable(release_o) && $stable(extended_o)));
endmodule

bind ps2_scan_receiver ps2_scan_receiver_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_o     (valid_o),
  .frame_err_o (frame_err_o),
  .code_o      (code_o),
  .release_o   (release_o),
  .extended_o  (extended_o),
  .byte_stb_w  (byte_stb_w),
  .bit_idx_w   (bit_idx_w),
  .timeout_w   (timeout_w)
);

// File: tb/test_ps2_scan_receiver.sv
`timescale 1ns/1ps
module test_ps2_scan_receiver;
  localparam int HALF = 12;
  localparam int GAP  = 40;
  localparam int TOUT = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kclk = 1'b1;
  logic       kdat = 1'b1;
  logic [7:0] code_o;
  logic       release_o, extended_o, valid_o, frame_err_o;

  int checks = 0, failures = 0;
  int ev_cnt = 0, err_cnt = 0;
  logic [7:0] cap_code = 8'h00;
  logic       cap_rel = 1'b0, cap_ext = 1'b0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ps2_scan_receiver #(.FILT_LEN(4), .TIMEOUT_CYC(TOUT)) i_ps2_scan_receiver (
    .clk(clk), .rst_n(rst_n), .ps2_clk_i(kclk), .ps2_dat_i(kdat),
    .code_o(code_o), .release_o(release_o), .extended_o(extended_o),
    .valid_o(valid_o), .frame_err_o(frame_err_o));

  always @(negedge clk) begin
    cycles++;
    if (valid_o) begin
      ev_cnt++;
      cap_code = code_o;
      cap_rel  = release_o;
      cap_ext  = extended_o;
    end
    if (frame_err_o) err_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // kind: 0 good, 1 parity flipped, 2 start high, 3 stop low
  function automatic logic [10:0] build(input logic [7:0] b, input int kind);
    int ones = 0;
    logic par;
    for (int i = 0; i < 8; i++) ones += b[i];
    par = (ones % 2 == 0);
    if (kind == 1) par = ~par;
    return {(kind == 3) ? 1'b0 : 1'b1, par, b, (kind == 2) ? 1'b1 : 1'b0};
  endfunction

  task automatic send_bits(input logic [10:0] f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); kdat = f[i];
      repeat (HALF / 2) @(negedge clk);
      kclk = 1'b0;
      repeat (HALF) @(negedge clk);
      kclk = 1'b1;
      repeat (HALF / 2) @(negedge clk);
    end
    kdat = 1'b1;
  endtask

  task automatic send(input logic [7:0] b, input int kind);
    send_bits(build(b, kind), 11);
    repeat (GAP) @(negedge clk);
  endtask

  task automatic expect_ev(input int base, input logic [7:0] c, input logic r,
                           input logic e, input string req);
    chk(ev_cnt == base + 1 && cap_code == c && cap_rel == r && cap_ext == e, req,
        {ev_cnt - base, 3'b0, cap_rel, 3'b0, cap_ext, cap_code},
        {32'd1, 3'b0, r, 3'b0, e, c});
  endtask

  task automatic expect_none(input int base, input int ebase, input string req);
    chk(ev_cnt == base && err_cnt == ebase, req, (ev_cnt - base) * 16 + (err_cnt - ebase), 0);
  endtask

  initial begin
    while (!done) begin
      @(negedge clk);
      if (cycles > 190000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    int b, eb;
    logic [7:0] k, held;
    repeat (10) @(negedge clk);
    // R1 reset state
    chk(code_o == 8'h00 && !release_o && !extended_o && !valid_o && !frame_err_o, "R1",
        {code_o, release_o, extended_o, valid_o, frame_err_o}, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R2 sweep of every non-prefix byte
    for (int v = 0; v < 256; v++) begin
      if (v == 8'hE0 || v == 8'hF0) continue;
      b = ev_cnt;
      send(8'(v), 0);
      expect_ev(b, 8'(v), 1'b0, 1'b0, "R2");
    end

    for (int i = 0; i < 12; i++) begin
      k = 8'(i * 19 + 3);
      // R4 release prefix, R10 outputs hold across prefix
      held = code_o;
      b = ev_cnt; eb = err_cnt;
      send(8'hF0, 0);
      expect_none(b, eb, "R4");
      chk(code_o == held, "R10", code_o, held);
      send(k, 0);
      expect_ev(b, k, 1'b1, 1'b0, "R4");
      // R6 flags cleared
      b = ev_cnt;
      send(8'h29, 0);
      expect_ev(b, 8'h29, 1'b0, 1'b0, "R6");
      // R5 extended, and extended release
      b = ev_cnt;
      send(8'hE0, 0);
      send(k, 0);
      expect_ev(b, k, 1'b0, 1'b1, "R5");
      b = ev_cnt;
      send(8'hE0, 0);
      send(8'hF0, 0);
      send(k, 0);
      expect_ev(b, k, 1'b1, 1'b1, "R5");
      b = ev_cnt;
      send(8'h1C, 0);
      expect_ev(b, 8'h1C, 1'b0, 1'b0, "R6");
    end

    // R3 framing errors
    for (int kind = 1; kind <= 3; kind++) begin
      for (int i = 0; i < 4; i++) begin
        held = code_o;
        b = ev_cnt; eb = err_cnt;
        send(8'(i * 61 + kind), kind);
        chk(ev_cnt == b && err_cnt == eb + 1, "R3", err_cnt - eb, 1);
        chk(code_o == held && !release_o && !extended_o, "R3", code_o, held);
      end
    end

    // R7 error drops pending prefixes
    b = ev_cnt;
    send(8'hF0, 0); send(8'h44, 1); send(8'h1C, 0);
    expect_ev(b, 8'h1C, 1'b0, 1'b0, "R7");
    b = ev_cnt;
    send(8'hE0, 0); send(8'h44, 2); send(8'h2D, 0);
    expect_ev(b, 8'h2D, 1'b0, 1'b0, "R7");

    // R8 truncated frame then stall
    for (int n = 1; n <= 9; n += 4) begin
      b = ev_cnt; eb = err_cnt;
      send_bits(build(8'h77, 0), n);
      repeat (TOUT + 100) @(negedge clk);
      send(8'h5A, 0);
      expect_ev(b, 8'h5A, 1'b0, 1'b0, "R8");
      chk(err_cnt == eb, "R8", err_cnt - eb, 0);
    end

    // R9 short glitches on the clock line
    b = ev_cnt; eb = err_cnt;
    for (int g = 0; g < 3; g++) begin
      @(negedge clk); kclk = 1'b0;
      repeat (2) @(negedge clk);
      kclk = 1'b1;
      repeat (20) @(negedge clk);
    end
    send(8'h33, 0);
    expect_ev(b, 8'h33, 1'b0, 1'b0, "R9");
    chk(err_cnt == eb, "R9", err_cnt - eb, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule